// File: doc/BRIEF.md
# Circular Row Window Buffer

The block takes a raster image stream packed four pixels to a 32-bit word and turns it into a stream of square pixel patches, one complete WIN x WIN neighbourhood per clock once enough rows are stored. Incoming words pass through a small word FIFO. An unpacker then hands out one pixel per cycle to a set of WIN row memories, and each of these holds exactly one image row. The memories are reused in rotation: each new row overwrites the slot whose row is no longer needed, so nothing outside the block holds any image rows.

Once WIN consecutive rows are stored, a reader fetches the same column from every row memory in one cycle. It rotates the slot outputs back into top-to-bottom image order and shifts that column into a WIN x WIN register window. Patches whose window would cross the image border are never emitted. Each valid patch comes out together with the image coordinates of its centre pixel. A frame-start pulse discards any partly received frame and puts the rotation back to slot 0.

Top module: `row_window_buf`

## Requirements
- R1: After reset, `in_ready` is 1 and `patch_valid` is 0.
- R2: Byte lane k of an accepted word (bits 8k+7 down to 8k) is the k-th pixel of that word in raster order, lane 0 first. Pixels fill each row left to right, with ROW_W pixels per row and ROWS rows per frame.
- R3: When `patch_valid` is 1, pixel (k, j) of the patch sits at bits (k*WIN+j)*PIX_W upward. It equals the image pixel at row `centre_y`-WIN/2+k and column `centre_x`-WIN/2+j.
- R4: In each frame, every centre with WIN/2 <= x <= ROW_W-1-WIN/2 and WIN/2 <= y <= ROWS-1-WIN/2 is emitted exactly once, in raster order, and no other centre is emitted.
- R5: A patch never mixes two rows. When `patch_valid` is 1 in two consecutive cycles, `centre_y` stays the same and `centre_x` increases by one.
- R6: `in_ready` is 0 only while the word FIFO holds FIFO_DEPTH words. A word offered while `in_ready` is 0 is not taken.
- R7: Row r of a frame goes into slot r mod WIN. A slot is written at column c only after the reader has fetched column c of the row it held before, so patch contents stay correct across slot reuse.
- R8: The slot pointers advance by one, modulo WIN, at each completed row. They return to 0 when a frame has been fully read out and whenever `frame_start` is 1, and `frame_start` also discards buffered words and partly received rows.
- R9: Each window row yields one run of exactly ROW_W-WIN+1 patches on consecutive cycles, and each run starts at `centre_x` = WIN/2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Restart pulse: clears row positions, slot pointers and the FIFO |
| in_valid | input | 1 | Input word offered |
| in_ready | output | 1 | Input word can be taken this cycle |
| in_data | input | WORD_W | Four packed pixels, lane 0 first |
| patch_valid | output | 1 | `patch` and the centre coordinates are valid |
| patch | output | WIN*WIN*PIX_W | Neighbourhood, row-major from the top left |
| centre_x | output | $clog2(ROW_W) | Column of the centre pixel |
| centre_y | output | $clog2(ROWS+1) | Row of the centre pixel |

## Verification
The corner cases are a frame restarted after two rows (a pointer that survives the restart puts row 0 in the wrong slot and scrambles the first frame), and the band where a slot is rewritten while still being read (a writer ahead of the reader corrupts lower-band patches). A run of full-rate words overfills the FIFO, and garbage is driven on the data lines while `in_ready` is low, so a word taken during the stall shows up as a wrong pixel. A ramp frame exposes a swapped lane order. Run lengths and start columns catch a window that emits a patch straddling two rows or one that touches the border.

// File: rtl/rwb_pkg.sv
package rwb_pkg;

  // next slot index in a ring of n slots
  function automatic int unsigned slot_step(int unsigned s, int unsigned n);
    return (s + 1 >= n) ? 0 : s + 1;
  endfunction

  // physical slot holding logical window row k when the top row sits in base
  function automatic int unsigned slot_rot(int unsigned base, int unsigned k, int unsigned n);
    return (base + k) % n;
  endfunction

  // may the writer place pixel (wrow, wcol) while the reader works on band rband at rcol
  function automatic bit row_write_allowed(int unsigned wrow, int unsigned wcol,
                                           int unsigned rband, int unsigned rcol,
                                           bit reading, int unsigned n, int unsigned rows);
    if (wrow >= rows) return 1'b0;
    if (wrow < rband + n) return 1'b1;
    return (wrow == rband + n) && reading && (wcol < rcol);
  endfunction

endpackage

// File: rtl/rwb_word_fifo.sv
module rwb_word_fifo #(
  parameter int WORD_W = 32,
  parameter int DEPTH  = 4,
  localparam int AW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int FCW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  input  logic              out_pop,
  output logic [FCW-1:0]    count
);
  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic push, pop;

  assign in_ready  = (count != FCW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rp];
  assign push = in_valid && in_ready;
  assign pop  = out_pop && out_valid;

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= in_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/rwb_unpack.sv
module rwb_unpack #(
  parameter int WORD_W = 32,
  parameter int PIX_W  = 8,
  localparam int LANES = WORD_W / PIX_W,
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word,
  output logic              word_pop,
  output logic              pix_valid,
  output logic [PIX_W-1:0]  pix,
  input  logic              pix_take
);
  logic [LW-1:0] lane;

  assign pix_valid = word_valid;
  assign pix       = word[lane*PIX_W +: PIX_W];
  assign word_pop  = pix_take && (lane == LW'(LANES - 1));

  always_ff @(posedge clk) begin
    if (rst || flush) lane <= '0;
    else if (pix_take) lane <= (lane == LW'(LANES - 1)) ? '0 : lane + 1'b1;
  end
endmodule

// File: rtl/rwb_row_bank.sv
module rwb_row_bank #(
  parameter int WIN   = 3,
  parameter int ROW_W = 16,
  parameter int PIX_W = 8,
  localparam int XW = $clog2(ROW_W),
  localparam int SW = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [SW-1:0]        wr_slot,
  input  logic [XW-1:0]        wr_col,
  input  logic [PIX_W-1:0]     wr_pix,
  input  logic                 rd_en,
  input  logic [XW-1:0]        rd_col,
  output logic [WIN*PIX_W-1:0] rd_q
);
  for (genvar s = 0; s < WIN; s++) begin : g_slot
    logic [PIX_W-1:0] row_mem [ROW_W];
    logic [PIX_W-1:0] q_r;

    always_ff @(posedge clk) begin
      if (wr_en && (wr_slot == SW'(s))) row_mem[wr_col] <= wr_pix;
      if (rd_en) q_r <= row_mem[rd_col];
    end

    assign rd_q[s*PIX_W +: PIX_W] = q_r;
  end
endmodule

// File: rtl/rwb_window.sv
module rwb_window import rwb_pkg::*; #(
  parameter int WIN   = 3,
  parameter int PIX_W = 8,
  parameter int XW    = 4,
  parameter int YW    = 4,
  localparam int SW   = (WIN > 1) ? $clog2(WIN) : 1
) (
  input  logic                     clk,
  input  logic                     clr,
  input  logic                     shift_en,
  input  logic [WIN*PIX_W-1:0]     slot_col,
  input  logic [SW-1:0]            base,
  input  logic [XW-1:0]            col,
  input  logic [YW-1:0]            band,
  output logic                     patch_valid,
  output logic [WIN*WIN*PIX_W-1:0] patch,
  output logic [XW-1:0]            centre_x,
  output logic [YW-1:0]            centre_y
);
  logic [PIX_W-1:0] ordered [WIN];
  logic [PIX_W-1:0] win [WIN][WIN];

  // undo the ring rotation: logical row k comes from slot (base+k) mod WIN
  always_comb begin
    for (int k = 0; k < WIN; k++) begin
      ordered[k] = slot_col[int'(slot_rot(32'(base), k, WIN)) * PIX_W +: PIX_W];
    end
  end

  always_ff @(posedge clk) begin
    if (shift_en) begin
      for (int k = 0; k < WIN; k++) begin
        win[k][0] <= ordered[k];
        for (int j = 1; j < WIN; j++) win[k][j] <= win[k][j-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      patch_valid <= 1'b0;
      centre_x <= '0;
      centre_y <= '0;
    end else begin
      patch_valid <= shift_en && (col >= XW'(WIN - 1));
      if (shift_en) begin
        centre_x <= col - XW'(WIN / 2);
        centre_y <= band + YW'(WIN / 2);
      end
    end
  end

  // column 0 of the register window holds the newest (rightmost) pixels
  for (genvar k = 0; k < WIN; k++) begin : g_prow
    for (genvar j = 0; j < WIN; j++) begin : g_pcol
      assign patch[(k*WIN + j)*PIX_W +: PIX_W] = win[k][WIN-1-j];
    end
  end
endmodule

// File: rtl/row_window_buf.sv
module row_window_buf import rwb_pkg::*; #(
  parameter int PIX_W      = 8,
  parameter int WORD_W     = 32,
  parameter int WIN        = 3,
  parameter int ROW_W      = 16,
  parameter int ROWS       = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int XW = $clog2(ROW_W),
  localparam int YW = $clog2(ROWS + 1)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     frame_start,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [WORD_W-1:0]        in_data,
  output logic                     patch_valid,
  output logic [WIN*WIN*PIX_W-1:0] patch,
  output logic [XW-1:0]            centre_x,
  output logic [YW-1:0]            centre_y
);
  localparam int SW  = (WIN > 1) ? $clog2(WIN) : 1;
  localparam int FCW = $clog2(FIFO_DEPTH + 1);
  localparam logic [XW-1:0] COL_LAST  = XW'(ROW_W - 1);
  localparam logic [YW-1:0] BAND_LAST = YW'(ROWS - WIN);
  localparam logic [YW-1:0] WIN_Y     = YW'(WIN);

  logic [WORD_W-1:0] head;
  logic head_valid, head_pop;
  logic [FCW-1:0] fifo_cnt;
  logic pix_valid;
  logic [PIX_W-1:0] pix;

  logic [XW-1:0] wr_col, rd_col;
  logic [YW-1:0] wr_row, rd_band;
  logic [SW-1:0] wr_slot, rd_base;
  logic reading;
  logic wr_fire, start_rd, frame_end;

  logic [WIN*PIX_W-1:0] bank_q;
  logic ld_v;
  logic [XW-1:0] ld_col;
  logic [YW-1:0] ld_band;
  logic [SW-1:0] ld_base;

  rwb_word_fifo #(.WORD_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .flush(frame_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(head_valid), .out_data(head), .out_pop(head_pop),
    .count(fifo_cnt)
  );

  rwb_unpack #(.WORD_W(WORD_W), .PIX_W(PIX_W)) u_unpack (
    .clk(clk), .rst(rst), .flush(frame_start),
    .word_valid(head_valid), .word(head), .word_pop(head_pop),
    .pix_valid(pix_valid), .pix(pix), .pix_take(wr_fire)
  );

  // writer: stays behind the reader whenever it reuses the slot being read
  assign wr_fire = pix_valid &&
                   row_write_allowed(32'(wr_row), 32'(wr_col), 32'(rd_band), 32'(rd_col),
                                     reading, WIN, ROWS);
  assign start_rd  = !reading && (wr_row >= rd_band + WIN_Y);
  assign frame_end = reading && (rd_col == COL_LAST) && (rd_band == BAND_LAST);

  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      wr_col <= '0;
      wr_row <= '0;
      wr_slot <= '0;
      rd_col <= '0;
      rd_band <= '0;
      rd_base <= '0;
      reading <= 1'b0;
    end else begin
      if (wr_fire) begin
        if (wr_col == COL_LAST) begin
          wr_col <= '0;
          wr_row <= wr_row + 1'b1;
          wr_slot <= SW'(slot_step(32'(wr_slot), WIN));
        end else begin
          wr_col <= wr_col + 1'b1;
        end
      end
      if (start_rd) begin
        reading <= 1'b1;
        rd_col <= '0;
      end else if (reading) begin
        if (rd_col == COL_LAST) begin
          reading <= 1'b0;
          rd_col <= '0;
          rd_band <= rd_band + 1'b1;
          rd_base <= SW'(slot_step(32'(rd_base), WIN));
        end else begin
          rd_col <= rd_col + 1'b1;
        end
      end
      if (frame_end) begin
        wr_row <= '0;
        wr_slot <= '0;
        rd_band <= '0;
        rd_base <= '0;
      end
    end
  end

  rwb_row_bank #(.WIN(WIN), .ROW_W(ROW_W), .PIX_W(PIX_W)) u_bank (
    .clk(clk),
    .wr_en(wr_fire), .wr_slot(wr_slot), .wr_col(wr_col), .wr_pix(pix),
    .rd_en(reading), .rd_col(rd_col), .rd_q(bank_q)
  );

  // align band, column and rotation with the registered memory read
  always_ff @(posedge clk) begin
    if (rst || frame_start) begin
      ld_v <= 1'b0;
      ld_col <= '0;
      ld_band <= '0;
      ld_base <= '0;
    end else begin
      ld_v <= reading;
      ld_col <= rd_col;
      ld_band <= rd_band;
      ld_base <= rd_base;
    end
  end

  rwb_window #(.WIN(WIN), .PIX_W(PIX_W), .XW(XW), .YW(YW)) u_win (
    .clk(clk), .clr(rst || frame_start),
    .shift_en(ld_v), .slot_col(bank_q), .base(ld_base),
    .col(ld_col), .band(ld_band),
    .patch_valid(patch_valid), .patch(patch),
    .centre_x(centre_x), .centre_y(centre_y)
  );
endmodule

// File: rtl/rwb_checker.sv
module rwb_checker import rwb_pkg::*; #(
  parameter int WIN        = 3,
  parameter int ROW_W      = 16,
  parameter int ROWS       = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int XW  = $clog2(ROW_W),
  localparam int YW  = $clog2(ROWS + 1),
  localparam int SW  = (WIN > 1) ? $clog2(WIN) : 1,
  localparam int FCW = $clog2(FIFO_DEPTH + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic           frame_start,
  input logic           in_ready,
  input logic [FCW-1:0] fifo_cnt,
  input logic           wr_fire,
  input logic [XW-1:0]  wr_col,
  input logic [SW-1:0]  wr_slot,
  input logic           reading,
  input logic [XW-1:0]  rd_col,
  input logic [SW-1:0]  rd_base,
  input logic           frame_end,
  input logic           patch_valid,
  input logic [XW-1:0]  centre_x,
  input logic [YW-1:0]  centre_y
);
  assert_ready_full_R6: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> (fifo_cnt == FCW'(FIFO_DEPTH)));

  assert_slot_range_R7: assert property (@(posedge clk) disable iff (rst)
    (32'(wr_slot) < WIN) && (32'(rd_base) < WIN));

  assert_no_clobber_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && reading && (wr_slot == rd_base)) |-> (wr_col < rd_col));

  assert_border_R4: assert property (@(posedge clk) disable iff (rst)
    patch_valid |-> (32'(centre_x) >= WIN/2) && (32'(centre_x) <= ROW_W-1-WIN/2) &&
                    (32'(centre_y) >= WIN/2) && (32'(centre_y) <= ROWS-1-WIN/2));

  assert_row_run_R5: assert property (@(posedge clk) disable iff (rst)
    (patch_valid && $past(patch_valid)) |->
      (centre_y == $past(centre_y)) && (centre_x == $past(centre_x) + 1'b1));

  assert_run_start_R9: assert property (@(posedge clk) disable iff (rst)
    (patch_valid && !$past(patch_valid)) |-> (32'(centre_x) == WIN/2));

  assert_slot_step_R8: assert property (@(posedge clk) disable iff (rst)
    (wr_fire && (wr_col == XW'(ROW_W-1)) && !frame_start) |=>
      (wr_slot == SW'(slot_step(32'($past(wr_slot)), WIN))));

  assert_frame_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    (frame_end || frame_start) |=> (wr_slot == '0) && (rd_base == '0));
endmodule

bind row_window_buf rwb_checker #(
  .WIN(WIN), .ROW_W(ROW_W), .ROWS(ROWS), .FIFO_DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start),
  .in_ready(in_ready), .fifo_cnt(fifo_cnt),
  .wr_fire(wr_fire), .wr_col(wr_col), .wr_slot(wr_slot),
  .reading(reading), .rd_col(rd_col), .rd_base(rd_base),
  .frame_end(frame_end),
  .patch_valid(patch_valid), .centre_x(centre_x), .centre_y(centre_y)
);

// File: tb/sim_row_window_buf.sv
`timescale 1ns/1ps
module sim_row_window_buf;
  localparam int PW = 8, WW = 32, N = 3, W = 16, H = 8, FD = 4, NF = 4;
  localparam int HALF = N / 2;
  localparam int PER_ROW = W - N + 1;
  localparam int PER_FRAME = PER_ROW * (H - N + 1);

  logic clk = 1'b0, rst = 1'b1, frame_start = 1'b0, in_valid = 1'b0;
  logic [WW-1:0] in_data = '0;
  wire in_ready, patch_valid;
  wire [N*N*PW-1:0] patch;
  wire [$clog2(W)-1:0] cx;
  wire [$clog2(H+1)-1:0] cy;

  row_window_buf #(.PIX_W(PW), .WORD_W(WW), .WIN(N), .ROW_W(W), .ROWS(H), .FIFO_DEPTH(FD)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .patch_valid(patch_valid), .patch(patch), .centre_x(cx), .centre_y(cy)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  byte unsigned img [NF][H][W];
  int mf = 0, ex = HALF, ey = HALF, run = 0, prev_y = 0;
  bit prev_valid = 1'b0, saw_stall = 1'b0;

  task automatic check(input bit ok, input string tag, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // expected neighbourhood pixel computed straight from the stored frame
  function automatic int exp_pix(int f, int y, int x);
    return int'(img[f][y][x]);
  endfunction

  always @(negedge clk) begin
    if (!rst) begin
      if (patch_valid) begin
        if (mf < NF) begin
          string tag;
          int mism = 0;
          if (mf == 0) tag = "R8";
          else if (mf == 1) tag = "R2";
          else if (ey > HALF) tag = "R7";
          else tag = "R3";
          check(int'(cx) == ex, "R4", "centre x", int'(cx), ex);
          check(int'(cy) == ey, "R4", "centre y", int'(cy), ey);
          if (prev_valid) check(int'(cy) == prev_y, "R5", "row changed inside run", int'(cy), prev_y);
          for (int k = 0; k < N; k++)
            for (int j = 0; j < N; j++)
              if (int'(patch[(k*N+j)*PW +: PW]) != exp_pix(mf, ey-HALF+k, ex-HALF+j)) mism++;
          check(mism == 0, tag, "mismatching patch pixels", mism, 0);
          run++;
          ex++;
          if (ex > W-1-HALF) begin
            ex = HALF;
            ey++;
            if (ey > H-1-HALF) begin
              ey = HALF;
              mf++;
            end
          end
        end else begin
          check(1'b0, "R4", "patch beyond last frame", int'(cy), -1);
        end
        prev_y = int'(cy);
      end else if (prev_valid) begin
        check(run == PER_ROW, "R9", "run length", run, PER_ROW);
        run = 0;
      end
      prev_valid = patch_valid;
    end
  end

  task automatic send_word(input logic [WW-1:0] w, input bit gaps);
    @(negedge clk);
    if (gaps && ($urandom % 3 == 0)) begin
      in_valid = 1'b0;
      @(negedge clk);
    end
    in_valid = 1'b1;
    while (!in_ready) begin
      saw_stall = 1'b1;
      in_data = $urandom;   // must be ignored while stalled
      @(negedge clk);
    end
    in_data = w;
    @(posedge clk);
  endtask

  task automatic send_frame(input int f, input bit gaps);
    for (int i = 0; i < W*H/4; i++) begin
      logic [WW-1:0] w;
      for (int k = 0; k < 4; k++) begin
        int p = 4*i + k;
        w[8*k +: 8] = img[f][p / W][p % W];
      end
      send_word(w, gaps);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    void'($urandom(32'h1d5e_0a17));
    for (int f = 0; f < NF; f++)
      for (int y = 0; y < H; y++)
        for (int x = 0; x < W; x++)
          case (f)
            1: img[f][y][x] = byte'((y*W + x) & 255);
            2: img[f][y][x] = ((x + y) % 2 == 0) ? 8'hFF : 8'h00;
            default: img[f][y][x] = byte'($urandom);
          endcase

    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "in_ready after reset", int'(in_ready), 1);
    check(patch_valid == 1'b0, "R1", "patch_valid after reset", int'(patch_valid), 0);

    // two rows of a frame that is then abandoned
    for (int i = 0; i < 2*W/4; i++) send_word($urandom, 1'b0);
    @(negedge clk);
    in_valid = 1'b0;
    repeat (10) @(negedge clk);
    check(patch_valid == 1'b0, "R4", "patch from two rows", int'(patch_valid), 0);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    check(in_ready == 1'b1, "R8", "in_ready after restart", int'(in_ready), 1);

    send_frame(0, 1'b1);
    send_frame(1, 1'b1);
    send_frame(2, 1'b1);
    send_frame(3, 1'b0);

    fork
      wait (mf >= NF);
      repeat (20000) @(posedge clk);
    join_any
    disable fork;
    repeat (20) @(negedge clk);
    check(mf == NF, "R4", "frames completed (watchdog)", mf, NF);
    check(mf*PER_FRAME + (ey-HALF)*PER_ROW + (ex-HALF) == NF*PER_FRAME, "R4",
          "total patches", mf*PER_FRAME + (ey-HALF)*PER_ROW + (ex-HALF), NF*PER_FRAME);
    check(saw_stall, "R6", "in_ready never dropped under full-rate input", int'(saw_stall), 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule